// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog peripheral that sits on a simple APB-style register bus. A down-counter runs from a programmable reload value. The first time the count reaches zero, the block raises an interrupt flag and starts the count again from the reload value. If software has not serviced the watchdog before the count reaches zero a second time, and the reset function is enabled, the block drives a system reset request. The worst-case time to reset is therefore two full count periods of (reload + 1) clock cycles each.

Software services the watchdog by writing any value to the interrupt-clear offset. That write drops the flag and restarts the count. A key register guards every other register: until the 32-bit unlock key is written, all other writes are dropped without effect. The bus has no wait states and no back-pressure. A write takes effect on the clock edge where select, enable and write are all high. Read data is a combinational function of the address.

Top module: `wdog2s_top`

## Requirements
- R1: After reset, the reload register (offset 0x000) and the count (0x004) read 0xFFFFFFFF, control (0x008) reads 0, raw status (0x010) reads 0, the key register (0xC00) reads 0 (unlocked), and both irq_o and wdt_rst_o are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, which then reads 0 there. Writing any other value locks it, and it then reads 1. While locked, writes to 0x000, 0x008 and 0x00C leave every register and output unchanged. Writes to 0xC00 are always accepted.
- R3: A write to 0x000 stores the value. It reads back at 0x000, and the count at 0x004 holds that same value from the next cycle.
- R4: The count decrements by one per cycle while control bit 0 (run) is set and is otherwise held.
- R5: When run is set and the count is zero, the next cycle has raw status bit 0 set and the count equal to the reload value.
- R6: A zero count with run set, raw status bit 0 already set and control bit 1 (reset enable) set asserts wdt_rst_o on the next cycle. wdt_rst_o stays high until the block is reset, even if control is cleared. With control bit 1 clear, no reset is asserted and the count keeps reloading.
- R7: Any write to 0x00C clears raw status and reloads the count. In the cycle where this write meets a zero count, the write wins: no flag sets and no reset is asserted.
- R8: Offset 0x014 bit 0 reads raw status AND control bit 0, and irq_o always equals that value. Clearing run clears irq_o but keeps raw status.
- R9: When control is written with 3 and the reload value is L, wdt_rst_o rises 2(L+1) cycles after the write edge. With L = 0 that is 2 cycles.
- R10: Control reads back in bits [1:0] of 0x008. Unused bits and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data for paddr |
| irq_o | output | 1 | Level interrupt (masked status) |
| wdt_rst_o | output | 1 | Sticky system reset request |

## Verification
Two functions can fall in the same cycle: a service write to the interrupt-clear offset, and the second expiry of the count with the flag pending and reset enabled. The bench sets a reload of 5 and enables both control bits. It then times the service write so that its access edge is exactly the edge of the second expiry. It judges that reset stays low, the flag is clear and the count has reloaded. A reference model, updated on every edge, is compared against the outputs and read data throughout, so the same collision is also judged against the model.

// File: rtl/wdog2s_pkg.sv
package wdog2s_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_RELOAD = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_SVC    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_KEY    = 12'hC00;

  localparam int unsigned CTRL_W   = 2;
  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_RST = 1;

  typedef struct packed {
    logic reload;
    logic ctrl;
    logic svc;
    logic key;
  } wr_hit_t;
endpackage

// File: rtl/wdog2s_decode.sv
module wdog2s_decode
  import wdog2s_pkg::*;
(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output wr_hit_t           hit
);
  logic wr_phase;

  assign wr_phase = psel & penable & pwrite;

  always_comb begin
    hit        = '0;
    hit.reload = wr_phase && (paddr == OFF_RELOAD);
    hit.ctrl   = wr_phase && (paddr == OFF_CTRL);
    hit.svc    = wr_phase && (paddr == OFF_SVC);
    hit.key    = wr_phase && (paddr == OFF_KEY);
  end
endmodule

// File: rtl/wdog2s_regs.sv
module wdog2s_regs
  import wdog2s_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_hit_t           hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reload_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              locked_q,
  output logic              reload_we,
  output logic              svc_we
);
  localparam logic [DATA_W-1:0] RELOAD_INIT = {DATA_W{1'b1}};

  logic open_w;

  assign open_w    = ~locked_q;
  assign reload_we = hit.reload & open_w;
  assign svc_we    = hit.svc & open_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
    end else if (hit.key) begin
      locked_q <= (wdata != UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_INIT;
    end else if (reload_we) begin
      reload_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (hit.ctrl && open_w) begin
      ctrl_q <= wdata[CTRL_W-1:0];
    end
  end
endmodule

// File: rtl/wdog2s_counter.sv
module wdog2s_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rst_en,
  input  logic [DATA_W-1:0] reload,
  input  logic              reload_we,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              svc_we,
  output logic [DATA_W-1:0] cnt_q,
  output logic              flag_q,
  output logic              rst_q
);
  localparam logic [DATA_W-1:0] CNT_INIT = {DATA_W{1'b1}};

  logic at_zero;
  logic expire;

  assign at_zero = (cnt_q == '0);
  assign expire  = run & at_zero & ~reload_we & ~svc_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
    end else if (reload_we) begin
      cnt_q <= reload_val;
    end else if (svc_we || expire) begin
      cnt_q <= reload;
    end else if (run) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (svc_we) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
    end else if (expire && flag_q && rst_en) begin
      rst_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog2s_top.sv
module wdog2s_top
  import wdog2s_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  wr_hit_t           hit;
  logic [DATA_W-1:0] reload_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              locked_q;
  logic              reload_we;
  logic              svc_we;
  logic [DATA_W-1:0] cnt_q;
  logic              flag_q;
  logic              masked;

  wdog2s_decode u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .hit     (hit)
  );

  wdog2s_regs #(
    .DATA_W     (DATA_W),
    .UNLOCK_KEY (UNLOCK_KEY)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .wdata     (pwdata),
    .reload_q  (reload_q),
    .ctrl_q    (ctrl_q),
    .locked_q  (locked_q),
    .reload_we (reload_we),
    .svc_we    (svc_we)
  );

  wdog2s_counter #(
    .DATA_W (DATA_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_q[CTRL_RUN]),
    .rst_en     (ctrl_q[CTRL_RST]),
    .reload     (reload_q),
    .reload_we  (reload_we),
    .reload_val (pwdata),
    .svc_we     (svc_we),
    .cnt_q      (cnt_q),
    .flag_q     (flag_q),
    .rst_q      (wdt_rst_o)
  );

  assign masked = flag_q & ctrl_q[CTRL_RUN];
  assign irq_o  = masked;

  always_comb begin
    prdata = '0;
    case (paddr)
      OFF_RELOAD: prdata = reload_q;
      OFF_COUNT:  prdata = cnt_q;
      OFF_CTRL:   prdata[CTRL_W-1:0] = ctrl_q;
      OFF_RAW:    prdata[0] = flag_q;
      OFF_MASK:   prdata[0] = masked;
      OFF_KEY:    prdata[0] = locked_q;
      default:    prdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog2s_chk.sv
module wdog2s_chk
  import wdog2s_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              irq_o,
  input logic              wdt_rst_o,
  input logic [DATA_W-1:0] reload_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              flag_q,
  input logic              locked_q
);
  logic bus_wr;
  logic cnt_touch;

  assign bus_wr    = psel & penable & pwrite;
  assign cnt_touch = bus_wr && !locked_q && (paddr == OFF_RELOAD || paddr == OFF_SVC);

  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && locked_q && paddr == OFF_RELOAD) |=> $stable(reload_q));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTRL_RUN] && cnt_q != '0 && !cnt_touch) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTRL_RUN] && !cnt_touch) |=> $stable(cnt_q));

  p_first_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTRL_RUN] && cnt_q == '0 && !flag_q && !cnt_touch)
      |=> (flag_q && cnt_q == $past(reload_q)));

  p_reset_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> wdt_rst_o);

  p_reset_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> ($past(flag_q) && $past(cnt_q) == '0 && $past(ctrl_q[CTRL_RST])));

  p_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !locked_q && paddr == OFF_SVC)
      |=> (!flag_q && cnt_q == $past(reload_q)));

  p_irq_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q && ctrl_q[CTRL_RUN]));
endmodule

bind wdog2s_top wdog2s_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .irq_o     (irq_o),
  .wdt_rst_o (wdt_rst_o),
  .reload_q  (reload_q),
  .cnt_q     (cnt_q),
  .ctrl_q    (ctrl_q),
  .flag_q    (flag_q),
  .locked_q  (locked_q)
);

// File: tb/wdog2s_tb_top.sv
`timescale 1ns/1ps
module wdog2s_tb_top;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_o;
  logic        wdt_rst_o;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_load, m_cnt;
  logic [1:0]  m_ctrl;
  logic        m_ris, m_lock, m_rst;

  always #10 clk = ~clk;

  wdog2s_top dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a)
      12'h000: return m_load;
      12'h004: return m_cnt;
      12'h008: return {30'd0, m_ctrl};
      12'h010: return {31'd0, m_ris};
      12'h014: return {31'd0, m_ris & m_ctrl[0]};
      12'hC00: return {31'd0, m_lock};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] o_load, o_cnt;
    logic [1:0]  o_ctrl;
    logic        o_ris, w, touched;
    if (!rst_n) begin
      m_load = '1; m_cnt = '1; m_ctrl = 0; m_ris = 0; m_lock = 0; m_rst = 0;
    end else begin
      o_load = m_load; o_cnt = m_cnt; o_ctrl = m_ctrl; o_ris = m_ris;
      w = psel && penable && pwrite;
      touched = 0;
      if (w && paddr == 12'hC00) m_lock = (pwdata != KEY);
      else if (w && !m_lock) begin
        if (paddr == 12'h000) begin m_load = pwdata; m_cnt = pwdata; touched = 1; end
        if (paddr == 12'h008) m_ctrl = pwdata[1:0];
        if (paddr == 12'h00C) begin m_cnt = o_load; m_ris = 0; touched = 1; end
      end
      if (!touched && o_ctrl[0]) begin
        if (o_cnt == 0) begin
          m_cnt = o_load;
          if (o_ris && o_ctrl[1]) m_rst = 1;
          m_ris = 1;
        end else m_cnt = o_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(prdata === exp_rd(paddr), "R10 read vs model", prdata, exp_rd(paddr));
      chk(irq_o === (m_ris & m_ctrl[0]), "R8 irq vs model", {31'd0, irq_o}, {31'd0, m_ris & m_ctrl[0]});
      chk(wdt_rst_o === m_rst, "R6 reset vs model", {31'd0, wdt_rst_o}, {31'd0, m_rst});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    paddr = a; pwdata = d; psel = 1; pwrite = 1; penable = 0;
    @(posedge clk); #2 penable = 1;
    @(posedge clk); #2 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    paddr = a; psel = 1; pwrite = 0; penable = 0;
    @(negedge clk);
    chk(prdata === exp, tag, prdata, exp);
    @(posedge clk); #2 psel = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; idle(3); rst_n = 1; idle(1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    int n;
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    rd(12'h000, 32'hFFFFFFFF, "R1 reload");
    rd(12'h004, 32'hFFFFFFFF, "R1 count");
    rd(12'h008, 0, "R1 ctrl");
    rd(12'h010, 0, "R1 raw");
    rd(12'hC00, 0, "R1 key");
    chk(!irq_o && !wdt_rst_o, "R1 outputs", {30'd0, irq_o, wdt_rst_o}, 0);
    // R10 unmapped
    rd(12'h018, 0, "R10 unmapped 018");
    rd(12'h800, 0, "R10 unmapped 800");
    // R3 reload write
    wr(12'h000, 32'd20);
    rd(12'h000, 32'd20, "R3 reload readback");
    rd(12'h004, 32'd20, "R3 count loaded");
    // R4 hold and count
    idle(3);
    rd(12'h004, 32'd20, "R4 held while stopped");
    wr(12'h008, 32'h1);
    idle(4);
    rd(12'h004, 32'd16, "R4 decrement");
    rd(12'h008, 32'h1, "R10 ctrl readback");
    // R5 first expiry
    n = 0;
    while (!irq_o && n < 200) begin idle(1); n++; end
    chk(irq_o, "R5 flag raised", {31'd0, irq_o}, 1);
    rd(12'h010, 1, "R5 raw status");
    rd(12'h014, 1, "R8 masked status");
    wr(12'h008, 32'h0);
    rd(12'h014, 0, "R8 masked after stop");
    rd(12'h010, 1, "R8 raw kept");
    chk(!irq_o, "R8 irq low after stop", {31'd0, irq_o}, 0);
    // R7 service
    wr(12'h00C, 32'h0);
    rd(12'h010, 0, "R7 flag cleared");
    rd(12'h004, 32'd20, "R7 count reloaded");
    // R6 no reset without enable
    wr(12'h000, 32'd2);
    wr(12'h008, 32'h1);
    idle(30);
    chk(!wdt_rst_o, "R6 no reset when disabled", {31'd0, wdt_rst_o}, 0);
    rd(12'h010, 1, "R6 flag pending");
    wr(12'h008, 32'h0);
    wr(12'h00C, 32'h0);
    // R2 lock
    wr(12'hC00, 32'h1);
    rd(12'hC00, 1, "R2 locked");
    wr(12'h000, 32'h55);
    wr(12'h008, 32'h3);
    rd(12'h000, 32'd2, "R2 reload ignored");
    rd(12'h008, 0, "R2 ctrl ignored");
    wr(12'hC00, KEY);
    rd(12'hC00, 0, "R2 unlocked");
    wr(12'hC00, 32'h1ACCE550);
    rd(12'hC00, 1, "R2 wrong key locks");
    wr(12'hC00, KEY);
    // R7 collision with second expiry
    wr(12'h000, 32'd5);
    wr(12'h008, 32'h3);
    idle(10);
    wr(12'h00C, 32'h0);
    chk(!wdt_rst_o, "R7 service wins over expiry", {31'd0, wdt_rst_o}, 0);
    rd(12'h004, 32'd5, "R7 count after collision");
    rd(12'h010, 0, "R7 flag after collision");
    wr(12'h008, 32'h0);
    // R9 timing
    wr(12'h000, 32'd3);
    wr(12'h008, 32'h3);
    n = 0;
    while (!wdt_rst_o && n < 100) begin idle(1); n++; end
    chk(n == 8, "R9 reset after 2(L+1)", n, 8);
    wr(12'h008, 32'h0);
    wr(12'h00C, 32'h0);
    chk(wdt_rst_o, "R6 reset sticky", {31'd0, wdt_rst_o}, 1);
    do_reset();
    chk(!wdt_rst_o, "R1 reset clears request", {31'd0, wdt_rst_o}, 0);
    wr(12'h000, 32'd0);
    wr(12'h008, 32'h3);
    n = 0;
    while (!wdt_rst_o && n < 100) begin idle(1); n++; end
    chk(n == 2, "R9 zero reload", n, 2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule